// File: doc/BRIEF.md
# Oversampled Serial Receive Front-End

This block turns an asynchronous, idle-high serial line into characters. A one-cycle enable, `tick16`, arrives at sixteen times the bit rate and clocks all bit timing. The line first passes through a synchronizer. A falling edge on it starts a tick counter. Half a bit later the line is checked again, and a pulse that has already returned high is dropped as a false start. Each accepted start bit is followed by 5 to 8 data bits, LSB first, then an optional parity bit and one stop bit. Each of these bits is sampled once, at its centre.

Every character is presented as one byte plus three flags: parity error, framing error and break. These leave on a valid/ready output. The serial line cannot be stalled, so back-pressure has limited reach. `out_valid` and the payload hold steady while `out_ready` is low. If a newer character completes before the held one is taken, the newer one replaces it. Data is accepted on any clock edge where both `out_valid` and `out_ready` are high.

Top module: `serial_rx_front`

## Requirements
- R1: After reset `out_valid` is low, and it stays low while the line remains high.
- R2: A falling edge starts a tick count. On the 8th `tick16` after the edge the synchronized line is sampled. If it is low the start bit is accepted. If it is high the event is a false start: no character is produced and the receiver returns to idle.
- R3: Each data bit is sampled 16 ticks after the previous sample and is shifted in LSB first. `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Output bits at and above the selected length are 0.
- R4: When `par_en` is 1, one parity bit follows the data. With `par_odd` 0 (even parity) the expected bit is the XOR of the data bits. With `par_odd` 1 it is the inverse of that XOR. A mismatch sets `out_par_err`. When `par_en` is 0, `out_par_err` is 0.
- R5: `out_frm_err` is 1 exactly when the sampled stop bit is 0.
- R6: `out_brk` is 1 exactly when every sampled data bit, the parity bit (if enabled) and the stop bit are 0. A break character therefore also carries `out_frm_err` = 1 and data 0.
- R7: After a character with a framing error, the receiver waits for the line to return high before it accepts a new start. A line held low produces no further characters.
- R8: `out_valid` and the payload hold until `out_ready` is high. A character that completes while an earlier one is still held replaces it. The earlier one is lost.
- R9: `word_len`, `par_en` and `par_odd` are captured when the start bit is accepted. Each character is framed with the settings in force at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Raw serial line, idle high |
| tick16 | input | 1 | Sampling enable, one cycle wide, at 16x the bit rate |
| word_len | input | 2 | Data bits: 0 selects 5, 1 selects 6, 2 selects 7, 3 selects 8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| out_ready | input | 1 | Consumer accepts the held character |
| out_valid | output | 1 | Character held on the output |
| out_data | output | 8 | Received data, LSB is the first bit received |
| out_par_err | output | 1 | Parity mismatch flag |
| out_frm_err | output | 1 | Stop bit was sampled as 0 |
| out_brk | output | 1 | Entire frame was sampled as 0 |

## Verification
The bench keeps the default sixteen-tick oversampling and two synchronizer stages. It pulses `tick16` on every second clock, so a bit lasts 32 clocks. Because the enable is not tied high, any timing that counts clocks instead of ticks shifts the sample points well away from the bit centres. With these settings, glitches of a few ticks fall clearly before the mid-start check, and all four word lengths fit in short frames. Break frames, odd and even parity, and back-pressure long enough to span two whole frames can all be reached within a few thousand cycles.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  parameter int unsigned CHAR_W = 8;
  parameter int unsigned WLEN_W = 2;
  parameter int unsigned MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAITHI
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
    logic              brk;
  } rx_char_t;

  function automatic logic [3:0] bits_for_code(input logic [WLEN_W-1:0] code);
    return 4'(MIN_BITS) + 4'(code);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              line_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '1;
      line_d <= 1'b1;
    end else begin
      chain  <= {chain[STAGES-2:0], line_in};
      line_d <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = line_d & ~chain[STAGES-1];
endmodule

// File: rtl/rx_bit_clock.sv
module rx_bit_clock #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic half,
  output logic strobe
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;
  localparam logic [CW-1:0] LIM_FULL = CW'(OSR - 1);
  localparam logic [CW-1:0] LIM_HALF = CW'(MID - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = half ? LIM_HALF : LIM_FULL;
  assign strobe = run && tick && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || strobe) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_s,
  input  logic              fall,
  input  logic              strobe,
  input  logic [WLEN_W-1:0] word_len,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              run,
  output logic              half,
  output rx_char_t          ch,
  output logic              ch_valid
);
  rx_state_e         state;
  logic [3:0]        nbits_q;
  logic              pen_q;
  logic              podd_q;
  logic [3:0]        bit_idx;
  logic [CHAR_W-1:0] sh;
  logic              par_acc;
  logic              any_one;
  logic              perr_q;
  logic [CHAR_W-1:0] aligned;

  assign run  = (state == ST_START) || (state == ST_DATA) ||
                (state == ST_PAR)   || (state == ST_STOP);
  assign half = (state == ST_START);

  always_comb begin
    aligned = sh >> (4'(CHAR_W) - nbits_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      nbits_q  <= 4'(CHAR_W);
      pen_q    <= 1'b0;
      podd_q   <= 1'b0;
      bit_idx  <= '0;
      sh       <= '0;
      par_acc  <= 1'b0;
      any_one  <= 1'b0;
      perr_q   <= 1'b0;
      ch       <= '0;
      ch_valid <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fall) state <= ST_START;
        end
        ST_START: begin
          if (strobe) begin
            if (!line_s) begin
              state   <= ST_DATA;
              nbits_q <= bits_for_code(word_len);
              pen_q   <= par_en;
              podd_q  <= par_odd;
              bit_idx <= '0;
              sh      <= '0;
              par_acc <= 1'b0;
              any_one <= 1'b0;
              perr_q  <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          if (strobe) begin
            sh      <= {line_s, sh[CHAR_W-1:1]};
            par_acc <= par_acc ^ line_s;
            any_one <= any_one | line_s;
            if (bit_idx == nbits_q - 1'b1) begin
              state <= pen_q ? ST_PAR : ST_STOP;
            end
            bit_idx <= bit_idx + 1'b1;
          end
        end
        ST_PAR: begin
          if (strobe) begin
            perr_q  <= line_s != (par_acc ^ podd_q);
            any_one <= any_one | line_s;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (strobe) begin
            ch.data    <= aligned;
            ch.par_err <= perr_q;
            ch.frm_err <= ~line_s;
            ch.brk     <= ~line_s & ~any_one;
            ch_valid   <= 1'b1;
            state      <= line_s ? ST_IDLE : ST_WAITHI;
          end
        end
        ST_WAITHI: begin
          if (line_s) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage
  import serial_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rx_char_t in_ch,
  input  logic     in_valid,
  input  logic     ready,
  output rx_char_t held,
  output logic     valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      valid <= 1'b0;
    end else if (in_valid) begin
      held  <= in_ch;
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_front.sv
module serial_rx_front
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              tick16,
  input  logic [WLEN_W-1:0] word_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              out_par_err,
  output logic              out_frm_err,
  output logic              out_brk
);
  logic     line_s;
  logic     fall;
  logic     run;
  logic     half;
  logic     strobe;
  rx_char_t frm_ch;
  logic     frm_valid;
  rx_char_t held;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_in (rx_line),
    .line_s  (line_s),
    .fall    (fall)
  );

  rx_bit_clock #(.OSR(OSR)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick16),
    .run    (run),
    .half   (half),
    .strobe (strobe)
  );

  rx_frame_ctrl u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s   (line_s),
    .fall     (fall),
    .strobe   (strobe),
    .word_len (word_len),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .run      (run),
    .half     (half),
    .ch       (frm_ch),
    .ch_valid (frm_valid)
  );

  rx_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ch    (frm_ch),
    .in_valid (frm_valid),
    .ready    (out_ready),
    .held     (held),
    .valid    (out_valid)
  );

  assign out_data    = held.data;
  assign out_par_err = held.par_err;
  assign out_frm_err = held.frm_err;
  assign out_brk     = held.brk;
endmodule

// File: rtl/serial_rx_front_chk.sv
module serial_rx_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic [1:0] word_len,
  input logic       par_en,
  input logic       out_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_par_err,
  input logic       out_frm_err,
  input logic       out_brk,
  input logic       frm_valid
);
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !frm_valid |=> $stable(out_data));

  a_r8_pop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frm_valid |=> !out_valid);

  a_r2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> $past(tick16));

  a_r8_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frm_valid));

  a_r6_brk_frm: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_brk |-> out_frm_err && out_data == 8'h00);

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && word_len == 2'd0 |-> out_data[7:5] == 3'b000);

  a_r4_no_par_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && $past(!par_en, 2) |-> !out_par_err);
endmodule

bind serial_rx_front serial_rx_front_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick16      (tick16),
  .word_len    (word_len),
  .par_en      (par_en),
  .out_ready   (out_ready),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_par_err (out_par_err),
  .out_frm_err (out_frm_err),
  .out_brk     (out_brk),
  .frm_valid   (frm_valid)
);

// File: tb/serial_rx_front_tb.sv
module serial_rx_front_tb;
  localparam int TDIV = 2;
  localparam int BITCLK = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       out_ready = 1'b1;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_par_err, out_frm_err, out_brk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [10:0] expq[$];

  always #4 clk = ~clk;

  serial_rx_front u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .word_len(word_len), .par_en(par_en), .par_odd(par_odd),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_par_err(out_par_err), .out_frm_err(out_frm_err), .out_brk(out_brk)
  );

  initial begin
    forever begin
      @(posedge clk); #1;
      tick16 = 1'b0;
      @(posedge clk); #1;
      tick16 = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic line_bit(input logic b);
    rx_line = b;
    wait_clk(BITCLK);
  endtask

  // One frame; bad_par flips the parity bit; stop_v sets the stop bit level.
  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic pe,
                      input logic po, input logic bad_par, input logic stop_v,
                      input bit push, input bit all_low);
    int n;
    logic [7:0] m;
    logic pb, perr, brk;
    n = 5 + int'(wl);
    m = d & 8'((1 << n) - 1);
    if (all_low) m = 8'h00;
    pb = (^m) ^ po;
    perr = 1'b0;
    if (bad_par) begin pb = ~pb; perr = pe; end
    if (all_low) begin pb = 1'b0; perr = pe && (pb != ((^m) ^ po)); end
    brk = (m == 8'h00) && (!pe || pb == 1'b0) && (stop_v == 1'b0);
    word_len = wl; par_en = pe; par_odd = po;
    if (push) expq.push_back({m, perr, ~stop_v, brk});
    line_bit(1'b0);
    for (int i = 0; i < n; i++) line_bit(m[i]);
    if (pe) line_bit(pb);
    line_bit(stop_v);
    rx_line = 1'b1;
  endtask

  // Monitor: compares every accepted character against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check("R2 unexpected character", {out_data, out_par_err, out_frm_err, out_brk}, 32'hFFFF_FFFF);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          check("R3 data", out_data, e[10:3]);
          check("R4 parity flag", out_par_err, e[2]);
          check("R5 framing flag", out_frm_err, e[1]);
          check("R6 break flag", out_brk, e[0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    wait_clk(150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(3);
    #2 check("R1 reset valid", out_valid, 1'b0);
    wait_clk(200);
    check("R1 idle valid", out_valid, 1'b0);

    // R3: all four word lengths, no parity
    send(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'h3C, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'hFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'hF5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(10);
    send(8'h01, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);

    // R4: even and odd parity, good and bad
    send(8'h37, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'h37, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'h5A, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); wait_clk(40);
    send(8'h0B, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); wait_clk(40);

    // R5: framing error with nonzero data
    send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); wait_clk(40);

    // R2: false starts of 3 and 6 ticks
    rx_line = 1'b0; wait_clk(3 * TDIV); rx_line = 1'b1; wait_clk(2 * BITCLK);
    rx_line = 1'b0; wait_clk(6 * TDIV); rx_line = 1'b1; wait_clk(2 * BITCLK);
    check("R2 false start queue", expq.size(), 0);
    send(8'h6E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);

    // R6/R7: break with odd parity (parity flag set), then line stays low
    send(8'h00, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    rx_line = 1'b0; wait_clk(4 * BITCLK);
    check("R7 no char while low", expq.size(), 0);
    rx_line = 1'b1; wait_clk(BITCLK);
    send(8'h00, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    rx_line = 1'b0; wait_clk(3 * BITCLK); rx_line = 1'b1; wait_clk(BITCLK);
    send(8'h99, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);

    // R8: back-pressure and replacement
    out_ready = 1'b0;
    send(8'h11, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); wait_clk(40);
    check("R8 held valid", out_valid, 1'b1);
    check("R8 held data", out_data, 8'h11);
    wait_clk(100);
    check("R8 still held", out_data, 8'h11);
    send(8'h22, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); wait_clk(40);
    check("R8 replaced data", out_data, 8'h22);
    out_ready = 1'b1;
    wait_clk(4);
    check("R8 drained", out_valid, 1'b0);

    // R9: settings change after start acceptance does not affect the frame
    word_len = 2'd3; par_en = 1'b0;
    expq.push_back({8'h15, 1'b0, 1'b0, 1'b0});
    line_bit(1'b0);
    word_len = 2'd0; par_en = 1'b1;
    for (int i = 0; i < 8; i++) line_bit(((8'h15 >> i) & 1) != 0);
    line_bit(1'b1);
    wait_clk(40);

    check("R3 scoreboard empty", expq.size(), 0);
    finish_run();
  end
endmodule